// File: doc/BRIEF.md
# Receive FIFO Drain Threshold Controller

This block decides when a receive FIFO may start handing the frame it is currently collecting to a host bus master. It adds up the bytes written for the frame. It raises a drain request as soon as that total reaches a programmable early-drain level, or when the last write of the frame arrives, whichever comes first. The request stays up until the bus master signals that the drain is finished. The byte count then returns to zero for the next frame.

Software picks the early-drain level with an enable bit and a 2-bit select. With the enable clear, the level is fixed at 64 bytes. With it set, the select chooses 32 bytes, 64 bytes or full store-and-forward, and the undefined fourth code falls back to store-and-forward. The settings are taken up only while no frame is in progress. From the first write of a frame until its drain completes, the frame keeps the level it started with.

Top module: `rx_drain_ctrl`

## Requirements
- R1: After reset `drain_req_o` is 0 and the frame byte count is zero.
- R2: With `thr_en_i` = 0 the active threshold is 64 bytes, whatever `thr_sel_i` holds, and `thr_bytes_o` reads 64.
- R3: With `thr_en_i` = 1, `thr_sel_i` = 2'b00 gives a 32-byte threshold and 2'b01 gives a 64-byte threshold, shown as 32 or 64 on `thr_bytes_o`.
- R4: With `thr_en_i` = 1, `thr_sel_i` = 2'b10 and the reserved 2'b11 both select store-and-forward. `thr_bytes_o` reads 0 and the request rises only on a write carrying `eof_i`.
- R5: A write (`wr_valid_i` = 1) whose bytes bring the frame total to the threshold or above raises `drain_req_o` in the next cycle. A total still below the threshold does not, and a cycle with no write never raises it.
- R6: A write with `eof_i` = 1 raises `drain_req_o` in the next cycle, whatever the byte total.
- R7: Once raised, `drain_req_o` stays 1 until `drain_done_i` = 1. Writes made while the request is up neither add to the count nor change the request or the threshold.
- R8: `drain_done_i` = 1 while the request is up drops `drain_req_o` in the next cycle and clears the byte count, so the next frame is counted from zero.
- R9: The threshold settings are taken from the inputs only while no frame is in progress. From the first write of a frame until its drain completes, the frame is judged against, and `thr_bytes_o` shows, the settings in force at that first write.
- R10: `drain_done_i` while no request is up has no effect on the request or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_en_i | input | 1 | Threshold select enable; 0 forces 64 bytes |
| thr_sel_i | input | 2 | Threshold select: 00 = 32 B, 01 = 64 B, 10/11 = store-and-forward |
| wr_valid_i | input | 1 | A frame write happens this cycle |
| wr_bytes_i | input | WB_W | Bytes carried by this write |
| eof_i | input | 1 | This write ends the frame (qualified by wr_valid_i) |
| drain_done_i | input | 1 | Bus master has finished draining the frame |
| drain_req_o | output | 1 | Drain may proceed |
| thr_bytes_o | output | CNT_W | Active threshold in bytes, 0 for store-and-forward |

## Verification
The bench builds the block with its defaults: a 4-byte word, levels of 8 and 16 words, an 8-bit write size and a 12-bit count. With 8-bit write sizes, a single write can land exactly on 32 or 64 bytes, stop one byte short, or overshoot. A few writes of up to 255 bytes each also carry a store-and-forward frame far past both levels before its last write. Changing the settings in the middle of a frame and pulsing the done input outside a request are then both within reach of a short run.

// File: rtl/rx_drain_pkg.sv
package rx_drain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_REQ  = 2'd2
  } drain_st_e;

  typedef enum logic [1:0] {
    SEL_LO  = 2'b00,
    SEL_HI  = 2'b01,
    SEL_SF  = 2'b10,
    SEL_RSV = 2'b11
  } thr_sel_e;

  typedef struct packed {
    logic     en;
    thr_sel_e sel;
  } thr_cfg_t;
endpackage

// File: rtl/rx_drain_cfg.sv
module rx_drain_cfg
  import rx_drain_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LO_BYTES = 32,
  parameter int HI_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             en_i,
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] thr_o,
  output logic             sf_o
);
  localparam logic [CNT_W-1:0] LO_T = CNT_W'(LO_BYTES);
  localparam logic [CNT_W-1:0] HI_T = CNT_W'(HI_BYTES);

  thr_cfg_t cfg_q, live, act;

  assign live.en  = en_i;
  assign live.sel = thr_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '{en: 1'b0, sel: SEL_HI};
    else if (!lock_i) cfg_q <= live;
  end

  // frame in progress: hold what the first write saw
  assign act = lock_i ? cfg_q : live;

  always_comb begin
    thr_o = HI_T;
    sf_o  = 1'b0;
    if (act.en) begin
      unique case (act.sel)
        SEL_LO:  thr_o = LO_T;
        SEL_HI:  thr_o = HI_T;
        default: begin
          thr_o = '0;
          sf_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_drain_fill.sv
module rx_drain_fill #(
  parameter int CNT_W = 12,
  parameter int WB_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             clr_i,
  input  logic [WB_W-1:0]  bytes_i,
  output logic [CNT_W-1:0] sum_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum_w;

  assign sum_w = {1'b0, cnt_q} + (CNT_W+1)'(bytes_i);
  // saturate rather than wrap
  assign sum_o = sum_w[CNT_W] ? '1 : sum_w[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (acc_i)  cnt_q <= sum_o;
  end
endmodule

// File: rtl/rx_drain_fsm.sv
module rx_drain_fsm
  import rx_drain_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             eof_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] sum_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             sf_i,
  output drain_st_e        st_o,
  output logic             acc_o,
  output logic             clr_o,
  output logic             lock_o
);
  drain_st_e st_q, st_d;
  logic      hit;

  assign hit = wr_i && (eof_i || (!sf_i && (sum_i >= thr_i)));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_FILL: if (wr_i) st_d = hit ? ST_REQ : ST_FILL;
      ST_REQ:           if (done_i) st_d = ST_IDLE;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o   = st_q;
  assign acc_o  = wr_i && (st_q != ST_REQ);
  assign clr_o  = (st_q == ST_REQ) && done_i;
  assign lock_o = (st_q != ST_IDLE);
endmodule

// File: rtl/rx_drain_ctrl.sv
module rx_drain_ctrl
  import rx_drain_pkg::*;
#(
  parameter int DW_BYTES = 4,
  parameter int LO_DW    = 8,
  parameter int HI_DW    = 16,
  parameter int WB_W     = 8,
  parameter int CNT_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             thr_en_i,
  input  logic [1:0]       thr_sel_i,
  input  logic             wr_valid_i,
  input  logic [WB_W-1:0]  wr_bytes_i,
  input  logic             eof_i,
  input  logic             drain_done_i,
  output logic             drain_req_o,
  output logic [CNT_W-1:0] thr_bytes_o
);
  localparam int LO_BYTES = LO_DW * DW_BYTES;
  localparam int HI_BYTES = HI_DW * DW_BYTES;

  drain_st_e        st_w;
  logic             acc_w, clr_w, lock_w, sf_w;
  logic [CNT_W-1:0] sum_w, thr_w;

  rx_drain_cfg #(.CNT_W(CNT_W), .LO_BYTES(LO_BYTES), .HI_BYTES(HI_BYTES)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (lock_w),
    .en_i   (thr_en_i),
    .sel_i  (thr_sel_i),
    .thr_o  (thr_w),
    .sf_o   (sf_w)
  );

  rx_drain_fill #(.CNT_W(CNT_W), .WB_W(WB_W)) u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc_w),
    .clr_i   (clr_w),
    .bytes_i (wr_bytes_i),
    .sum_o   (sum_w)
  );

  rx_drain_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_valid_i),
    .eof_i  (eof_i),
    .done_i (drain_done_i),
    .sum_i  (sum_w),
    .thr_i  (thr_w),
    .sf_i   (sf_w),
    .st_o   (st_w),
    .acc_o  (acc_w),
    .clr_o  (clr_w),
    .lock_o (lock_w)
  );

  assign drain_req_o = (st_w == ST_REQ);
  assign thr_bytes_o = thr_w;
endmodule

// File: rtl/rx_drain_chk.sv
module rx_drain_chk
  import rx_drain_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LO_BYTES = 32,
  parameter int HI_BYTES = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             thr_en_i,
  input logic             wr_valid_i,
  input logic             eof_i,
  input logic             drain_done_i,
  input logic             drain_req_o,
  input logic [CNT_W-1:0] thr_bytes_o,
  input drain_st_e        st_i
);
  localparam logic [CNT_W-1:0] LO_T = CNT_W'(LO_BYTES);
  localparam logic [CNT_W-1:0] HI_T = CNT_W'(HI_BYTES);

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_req_o && !drain_done_i |=> drain_req_o);

  assert_done_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_req_o && drain_done_i |=> !drain_req_o);

  assert_no_write_no_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drain_req_o && !wr_valid_i |=> !drain_req_o);

  assert_default_thr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) && !thr_en_i |-> thr_bytes_o == HI_T);

  assert_legal_thr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_bytes_o == '0 || thr_bytes_o == LO_T || thr_bytes_o == HI_T);

  assert_sf_needs_eof_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drain_req_o) && thr_bytes_o == '0 |-> $past(wr_valid_i && eof_i));

  assert_thr_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_IDLE) && ($past(st_i) != ST_IDLE) |-> $stable(thr_bytes_o));
endmodule

bind rx_drain_ctrl rx_drain_chk #(
  .CNT_W(CNT_W), .LO_BYTES(LO_BYTES), .HI_BYTES(HI_BYTES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .thr_en_i     (thr_en_i),
  .wr_valid_i   (wr_valid_i),
  .eof_i        (eof_i),
  .drain_done_i (drain_done_i),
  .drain_req_o  (drain_req_o),
  .thr_bytes_o  (thr_bytes_o),
  .st_i         (st_w)
);

// File: tb/rx_drain_ctrl_bench.sv
module rx_drain_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int WB_W  = 8;
  localparam int CNT_W = 12;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             thr_en_i = 1'b0;
  logic [1:0]       thr_sel_i = 2'b01;
  logic             wr_valid_i = 1'b0;
  logic [WB_W-1:0]  wr_bytes_i = '0;
  logic             eof_i = 1'b0;
  logic             drain_done_i = 1'b0;
  logic             drain_req_o;
  logic [CNT_W-1:0] thr_bytes_o;

  int n_vec = 0;
  int n_bad = 0;

  // reference model state: 0 idle, 1 filling, 2 requesting
  int m_st = 0;
  int m_cnt = 0;
  bit m_en = 1'b0;
  bit [1:0] m_sel = 2'b01;

  always #(CLK_P/2) clk_i = ~clk_i;

  rx_drain_ctrl u_rx_drain_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .thr_en_i     (thr_en_i),
    .thr_sel_i    (thr_sel_i),
    .wr_valid_i   (wr_valid_i),
    .wr_bytes_i   (wr_bytes_i),
    .eof_i        (eof_i),
    .drain_done_i (drain_done_i),
    .drain_req_o  (drain_req_o),
    .thr_bytes_o  (thr_bytes_o)
  );

  function automatic int ref_thr(bit en, bit [1:0] sel);
    if (!en) return 64;
    if (sel == 2'b00) return 32;
    if (sel == 2'b01) return 64;
    return 0;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic step(input bit en, input bit [1:0] sel, input bit wr, input int nb,
                      input bit eof, input bit done, input string rq);
    int exp_thr;
    bit exp_req;
    bit a_en;
    bit [1:0] a_sel;
    int sum;
    thr_en_i     = en;
    thr_sel_i    = sel;
    wr_valid_i   = wr;
    wr_bytes_i   = WB_W'(nb);
    eof_i        = eof;
    drain_done_i = done;
    #1;
    exp_req = (m_st == 2);
    exp_thr = (m_st == 0) ? ref_thr(en, sel) : ref_thr(m_en, m_sel);
    n_vec++;
    if (drain_req_o !== exp_req) begin
      n_bad++;
      $display("FAIL %s drain_req_o got %0b expected %0b at %0t", rq, drain_req_o, exp_req, $time);
    end
    if (thr_bytes_o !== CNT_W'(exp_thr)) begin
      n_bad++;
      $display("FAIL %s thr_bytes_o got %0d expected %0d at %0t", rq, thr_bytes_o, exp_thr, $time);
    end
    @(posedge clk_i);
    if (m_st != 2) begin
      if (m_st == 0) begin
        m_en  = en;
        m_sel = sel;
      end
      a_en  = m_en;
      a_sel = m_sel;
      if (wr) begin
        sum = m_cnt + nb;
        if (sum > CMAX) sum = CMAX;
        m_cnt = sum;
        if (eof || (!(a_en && a_sel[1]) && sum >= ref_thr(a_en, a_sel))) m_st = 2;
        else m_st = 1;
      end
    end else if (done) begin
      m_st  = 0;
      m_cnt = 0;
    end
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    // R1: reset state
    n_vec++;
    if (drain_req_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 drain_req_o got %0b expected 0 in reset", drain_req_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(0, 2'b01, 0, 0, 0, 0, "R1");

    // R2: enable low overrides select; 4 x 16 = 64
    for (int i = 0; i < 4; i++) step(0, 2'b00, 1, 16, 0, 0, "R2");
    // R7: writes during request ignored
    for (int i = 0; i < 3; i++) step(1, 2'b10, 1, 50, 1, 0, "R7");
    step(0, 2'b00, 0, 0, 0, 1, "R8");

    // R3: 32-byte level, R5 boundary 31 then +1
    step(1, 2'b00, 1, 31, 0, 0, "R5");
    step(1, 2'b00, 0, 0, 0, 0, "R5");
    step(1, 2'b00, 1, 1, 0, 0, "R3");
    step(1, 2'b00, 0, 0, 0, 0, "R3");
    step(1, 2'b00, 0, 0, 0, 1, "R8");

    // R3: 64-byte level, overshoot
    for (int i = 0; i < 3; i++) step(1, 2'b01, 1, 20, 0, 0, "R3");
    step(1, 2'b01, 1, 20, 0, 0, "R3");
    step(1, 2'b01, 0, 0, 0, 1, "R8");

    // R4: store-and-forward, with R10 done while no request
    for (int i = 0; i < 4; i++) step(1, 2'b10, 1, 200, 0, 0, "R4");
    step(1, 2'b10, 0, 0, 0, 1, "R10");
    step(1, 2'b10, 1, 7, 1, 0, "R4");
    step(1, 2'b10, 0, 0, 0, 0, "R7");
    step(1, 2'b10, 0, 0, 0, 1, "R8");

    // R4: reserved code behaves as store-and-forward
    for (int i = 0; i < 5; i++) step(1, 2'b11, 1, 255, 0, 0, "R4");
    step(1, 2'b11, 1, 0, 1, 0, "R4");
    step(1, 2'b11, 0, 0, 0, 1, "R8");

    // R6: short frame ends below threshold
    step(1, 2'b01, 1, 10, 1, 0, "R6");
    step(1, 2'b01, 0, 0, 0, 1, "R8");

    // R10: done pulses in idle
    step(1, 2'b00, 0, 0, 0, 1, "R10");
    step(1, 2'b00, 1, 30, 0, 1, "R10");

    // R9: settings change mid-frame are not taken up
    step(1, 2'b10, 1, 1, 0, 0, "R9");
    step(0, 2'b11, 0, 0, 0, 0, "R9");
    step(1, 2'b01, 1, 1, 0, 0, "R9");
    step(1, 2'b11, 0, 0, 0, 0, "R9");
    step(1, 2'b10, 0, 0, 0, 1, "R8");

    // R8: next frame starts from zero
    step(1, 2'b00, 1, 24, 0, 0, "R8");
    step(1, 2'b00, 1, 7, 0, 0, "R8");
    step(1, 2'b00, 0, 0, 0, 0, "R8");
    step(1, 2'b00, 1, 1, 0, 0, "R5");
    step(0, 2'b01, 0, 0, 0, 0, "R7");
    step(0, 2'b01, 0, 0, 0, 1, "R8");
    step(0, 2'b01, 0, 0, 0, 0, "R2");

    summary();
    $finish;
  end
endmodule